// File: doc/BRIEF.md
# Clock, Reset and Power-Mode Controller

This block turns a free-running oscillator clock into the enables that pace a small 8-bit controller core and its peripherals. A mode input sets the rate. In the normal rate the oscillator is halved, so one enable falls on every second clock. In the double-speed rate the halving is skipped, so every clock carries an enable. Each run of six enables forms one machine cycle. The last enable of each run is flagged with a strobe, and a phase index is given out with it.

The block also qualifies the external reset pin. Internal reset rises only after the pin has stayed high for two whole machine cycles of enables. The port latches, however, are forced high at once through a separate output. The block also runs two low-power modes:
- Idle stops the CPU enable and keeps the peripheral enable running. A pending interrupt or a reset wakes it.
- Power-down stops every enable. Only a reset wakes it.

A RAM-clear inhibit output is held low so that reset never clears the internal data RAM.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: With the rate latch at 0, cpu_en_o and periph_en_o are high on exactly one clock in every two, so any 24 consecutive running clocks hold 12 enables and machine-cycle strobes are 12 clocks apart.
- R2: With the rate latch at 1, every running clock carries an enable: 24 enables in 24 clocks, and strobes 6 clocks apart.
- R3: The rate latch copies x2_mode_i only while core_rst_o is high. A change of x2_mode_i during normal running leaves the strobe spacing unchanged until the next internal reset.
- R4: mcycle_o marks the sixth peripheral enable of every machine cycle, with 6 CPU enables between two strobes. The phase index restarts at 0 when internal reset falls, so the first machine cycle after reset also has 6 enables.
- R5: core_rst_o rises only after rst_pin_i has been high across 12 consecutive enable ticks (two machine cycles). It is still low 22 clocks after the pin rises in normal rate, and high after 24 clocks. A shorter pulse does not reset and does not stop the enables. The internal reset falls on the first clock edge that sees the pin low.
- R6: port_force_o is high in the same clock as rst_pin_i is high, with no edge in between, and it stays high while core_rst_o is high.
- R7: An idle request, taken on a CPU enable, stops cpu_en_o while periph_en_o keeps its rate. Flag bit 0 of mode_flags_o reads 1.
- R8: In idle, irq_pend_i returns the core to running, and cpu_en_o resumes at its full rate.
- R9: A power-down request, taken on a CPU enable, stops cpu_en_o, periph_en_o and mcycle_o. Flag bit 1 reads 1. irq_pend_i has no effect in this mode. Only an internal reset leaves it.
- R10: When idle and power-down are requested on the same CPU enable, power-down is entered.
- R11: mode_flags_o is 0 while internal reset holds and after it. Bits 7..2 always read 0.
- R12: ram_clr_o is low at all times, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_i | input | 1 | External reset pin, active high |
| x2_mode_i | input | 1 | Rate select: 1 bypasses the divide-by-two |
| idle_req_i | input | 1 | Idle request from the core |
| pdown_req_i | input | 1 | Power-down request from the core |
| irq_pend_i | input | 1 | Enabled interrupt pending |
| cpu_en_o | output | 1 | CPU clock enable |
| periph_en_o | output | 1 | Timer, serial and interrupt clock enable |
| mcycle_o | output | 1 | Last-phase strobe of a machine cycle |
| phase_o | output | PH_W | Current phase index 0..PHASES-1 |
| core_rst_o | output | 1 | Qualified internal reset |
| port_force_o | output | 1 | Forces port latches to ones |
| ram_clr_o | output | 1 | RAM-clear command, held low |
| mode_flags_o | output | 8 | Bit 0 idle, bit 1 power-down, others 0 |

## Verification
Several functions can land on the same CPU enable, and the bench covers three such cases. In the first, the idle and power-down requests are raised together. The result is judged by the flag value and by the peripheral enable count that follows: the flag must read power-down and no enables may follow. In the second, an interrupt is raised while the core is in power-down, and the bench checks that the enables stay off. In the third, a reset pin pulse runs while the core is in a low-power mode, and the bench checks that the flags clear and the enables recover to the rate chosen.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pmode_e;

  localparam int unsigned FLAG_W = 8;
endpackage

// File: rtl/cpc_clk_div.sv
module cpc_clk_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x2_mode_i,
  input  logic core_rst_i,
  output logic tick_o,
  output logic x2_q_o
);
  logic div_q;
  logic x2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= ~div_q;
  end

  // rate latch only follows the pin under internal reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         x2_q <= 1'b0;
    else if (core_rst_i) x2_q <= x2_mode_i;
  end

  assign tick_o = x2_q | div_q;
  assign x2_q_o = x2_q;
endmodule

// File: rtl/cpc_rst_qual.sv
module cpc_rst_qual #(
  parameter int unsigned PHASES    = 6,
  parameter int unsigned QUAL_MCYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_pin_i,
  input  logic tick_i,
  output logic core_rst_o
);
  localparam int unsigned LIMIT = PHASES * QUAL_MCYC;
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rst_q <= 1'b1;
    end else if (!rst_pin_i) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else if (tick_i && !rst_q) begin
      if (cnt_q == CW'(LIMIT - 1)) begin
        cnt_q <= '0;
        rst_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign core_rst_o = rst_q;
endmodule

// File: rtl/cpc_phase_seq.sv
module cpc_phase_seq #(
  parameter int unsigned PHASES = 6,
  localparam int unsigned PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            adv_i,
  output logic [PH_W-1:0] phase_o,
  output logic            strobe_o
);
  logic [PH_W-1:0] ph_q;
  logic            last;

  assign last = (ph_q == PH_W'(PHASES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (clr_i)  ph_q <= '0;
    else if (adv_i)  ph_q <= last ? '0 : ph_q + 1'b1;
  end

  assign phase_o  = ph_q;
  assign strobe_o = adv_i & last;
endmodule

// File: rtl/cpc_pwr_fsm.sv
module cpc_pwr_fsm
  import cpc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   core_rst_i,
  input  logic   cpu_tick_i,
  input  logic   idle_req_i,
  input  logic   pdown_req_i,
  input  logic   irq_pend_i,
  output pmode_e mode_o
);
  pmode_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PM_RUN: begin
        // power-down wins over idle
        if (cpu_tick_i && pdown_req_i)     st_d = PM_DOWN;
        else if (cpu_tick_i && idle_req_i) st_d = PM_IDLE;
      end
      PM_IDLE: if (irq_pend_i) st_d = PM_RUN;
      PM_DOWN: st_d = PM_DOWN;
      default: st_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         st_q <= PM_RUN;
    else if (core_rst_i) st_q <= PM_RUN;
    else                 st_q <= st_d;
  end

  assign mode_o = st_q;
endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
  import cpc_pkg::*;
#(
  parameter int unsigned PHASES    = 6,
  parameter int unsigned QUAL_MCYC = 2,
  localparam int unsigned PH_W     = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_i,
  input  logic              x2_mode_i,
  input  logic              idle_req_i,
  input  logic              pdown_req_i,
  input  logic              irq_pend_i,
  output logic              cpu_en_o,
  output logic              periph_en_o,
  output logic              mcycle_o,
  output logic [PH_W-1:0]   phase_o,
  output logic              core_rst_o,
  output logic              port_force_o,
  output logic              ram_clr_o,
  output logic [FLAG_W-1:0] mode_flags_o
);
  logic   tick;
  logic   x2_q;
  logic   core_rst;
  logic   run_ok;
  logic   cpu_en;
  logic   per_en;
  pmode_e mode;

  cpc_clk_div u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .x2_mode_i  (x2_mode_i),
    .core_rst_i (core_rst),
    .tick_o     (tick),
    .x2_q_o     (x2_q)
  );

  cpc_rst_qual #(
    .PHASES    (PHASES),
    .QUAL_MCYC (QUAL_MCYC)
  ) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_pin_i  (rst_pin_i),
    .tick_i     (tick),
    .core_rst_o (core_rst)
  );

  cpc_pwr_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .core_rst_i  (core_rst),
    .cpu_tick_i  (cpu_en),
    .idle_req_i  (idle_req_i),
    .pdown_req_i (pdown_req_i),
    .irq_pend_i  (irq_pend_i),
    .mode_o      (mode)
  );

  assign run_ok = tick & ~core_rst;
  assign cpu_en = run_ok & (mode == PM_RUN);
  assign per_en = run_ok & (mode != PM_DOWN);

  cpc_phase_seq #(
    .PHASES (PHASES)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (core_rst),
    .adv_i    (per_en),
    .phase_o  (phase_o),
    .strobe_o (mcycle_o)
  );

  assign cpu_en_o     = cpu_en;
  assign periph_en_o  = per_en;
  assign core_rst_o   = core_rst;
  // ports go high straight from the pin, before qualification
  assign port_force_o = rst_pin_i | core_rst;
  assign ram_clr_o    = 1'b0;

  always_comb begin
    mode_flags_o    = '0;
    mode_flags_o[0] = (mode == PM_IDLE);
    mode_flags_o[1] = (mode == PM_DOWN);
  end
endmodule

// File: rtl/clk_pwr_ctrl_chk.sv
module clk_pwr_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rst_pin_i,
  input logic       idle_req_i,
  input logic       pdown_req_i,
  input logic       cpu_en_o,
  input logic       periph_en_o,
  input logic       mcycle_o,
  input logic       core_rst_o,
  input logic       port_force_o,
  input logic [7:0] mode_flags_o,
  input logic       x2_q
);
  // R4
  strobe_in_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcycle_o |-> periph_en_o);

  // R7
  cpu_sub_periph_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_en_o |-> periph_en_o);

  // R9
  pd_all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_flags_o[1] |-> (!periph_en_o && !cpu_en_o && !mcycle_o));

  // R9
  pd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_flags_o[1] && !rst_pin_i) |=> mode_flags_o[1]);

  // R5
  qual_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> $past(rst_pin_i));

  // R6
  port_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pin_i |-> port_force_o);

  // R3
  x2_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_rst_o && !$past(core_rst_o)) |-> $stable(x2_q));

  // R10
  both_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdown_req_i && idle_req_i && cpu_en_o && !rst_pin_i) |=> mode_flags_o[1]);

  // R11
  flags_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_o && $past(core_rst_o)) |-> (mode_flags_o == 8'h00));
endmodule

bind clk_pwr_ctrl clk_pwr_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rst_pin_i    (rst_pin_i),
  .idle_req_i   (idle_req_i),
  .pdown_req_i  (pdown_req_i),
  .cpu_en_o     (cpu_en_o),
  .periph_en_o  (periph_en_o),
  .mcycle_o     (mcycle_o),
  .core_rst_o   (core_rst_o),
  .port_force_o (port_force_o),
  .mode_flags_o (mode_flags_o),
  .x2_q         (x2_q)
);

// File: tb/clk_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module clk_pwr_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rst_pin = 1'b0;
  logic       x2 = 1'b0;
  logic       idle_req = 1'b0;
  logic       pd_req = 1'b0;
  logic       irq = 1'b0;
  logic       cpu_en, per_en, mcyc, core_rst, pforce, ram_clr;
  logic [2:0] phase;
  logic [7:0] flags;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  clk_pwr_ctrl u_clk_pwr_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .rst_pin_i    (rst_pin),
    .x2_mode_i    (x2),
    .idle_req_i   (idle_req),
    .pdown_req_i  (pd_req),
    .irq_pend_i   (irq),
    .cpu_en_o     (cpu_en),
    .periph_en_o  (per_en),
    .mcycle_o     (mcyc),
    .phase_o      (phase),
    .core_rst_o   (core_rst),
    .port_force_o (pforce),
    .ram_clr_o    (ram_clr),
    .mode_flags_o (flags)
  );

  // x2, request kind (0 none 1 idle 2 pd 3 both), cpu/24, periph/24, flags, cpu/24 after irq
  typedef struct packed {
    logic       x2;
    logic [1:0] req;
    logic [4:0] cpu;
    logic [4:0] per;
    logic [1:0] flg;
    logic [4:0] cpu_irq;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 2'd0, 5'd12, 5'd12, 2'd0, 5'd12},
    '{1'b0, 2'd1, 5'd0,  5'd12, 2'd1, 5'd12},
    '{1'b0, 2'd2, 5'd0,  5'd0,  2'd2, 5'd0},
    '{1'b0, 2'd3, 5'd0,  5'd0,  2'd2, 5'd0},
    '{1'b1, 2'd0, 5'd24, 5'd24, 2'd0, 5'd24},
    '{1'b1, 2'd1, 5'd0,  5'd24, 2'd1, 5'd24},
    '{1'b1, 2'd2, 5'd0,  5'd0,  2'd2, 5'd0},
    '{1'b1, 2'd3, 5'd0,  5'd0,  2'd2, 5'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pin_reset(input logic rate);
    @(negedge clk);
    rst_pin = 1'b1;
    x2 = rate;
    repeat (30) @(negedge clk);
    rst_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic count_en(input int n, output int c_cpu, output int c_per);
    c_cpu = 0;
    c_per = 0;
    repeat (n) begin
      @(negedge clk);
      c_cpu += int'(cpu_en);
      c_per += int'(per_en);
    end
  endtask

  task automatic gap_meas(output int gap, output int c_cpu);
    int g = 0;
    do begin @(negedge clk); g++; end while (!mcyc && g < 100);
    gap = 0;
    c_cpu = 0;
    do begin
      @(negedge clk);
      gap++;
      c_cpu += int'(cpu_en);
    end while (!mcyc && gap < 100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a, b, n;
    repeat (3) @(negedge clk);
    // reset state, R11 R12
    chk("R11 reset core_rst", int'(core_rst), 1);
    chk("R11 reset flags", int'(flags), 0);
    chk("R12 ram_clr in reset", int'(ram_clr), 0);
    chk("R6 port_force under core reset", int'(pforce), 1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 release with pin low", int'(core_rst), 0);

    // R6 immediate force, R5 qualification window
    rst_pin = 1'b1;
    #1;
    chk("R6 port_force same cycle", int'(pforce), 1);
    repeat (22) @(negedge clk);
    chk("R5 not yet after 22 clocks", int'(core_rst), 0);
    repeat (2) @(negedge clk);
    chk("R5 asserted after 24 clocks", int'(core_rst), 1);
    chk("R12 ram_clr during reset", int'(ram_clr), 0);

    // R4 first machine cycle complete after release
    rst_pin = 1'b0;
    n = 0;
    a = 0;
    do begin
      if (per_en) n++;
      a++;
      @(negedge clk);
    end while (!mcyc && a < 100);
    if (per_en) n++;
    chk("R4 first cycle enables", n, 6);
    gap_meas(a, b);
    chk("R1 strobe spacing normal", a, 12);
    chk("R4 cpu enables per cycle", b, 6);

    // R5 short pulse ignored
    @(negedge clk);
    rst_pin = 1'b1;
    repeat (20) @(negedge clk);
    chk("R5 short pulse no reset", int'(core_rst), 0);
    rst_pin = 1'b0;
    count_en(24, a, b);
    chk("R5 enables after short pulse", a, 12);

    // R3 rate pin ignored while running
    x2 = 1'b1;
    repeat (10) @(negedge clk);
    gap_meas(a, b);
    chk("R3 spacing unchanged mid-run", a, 12);
    pin_reset(1'b1);
    gap_meas(a, b);
    chk("R2 strobe spacing double", a, 6);
    chk("R4 cpu enables per cycle x2", b, 6);

    // table walk: modes, collisions, wake rules
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      string tag_cpu, tag_irq;
      pin_reset(v.x2);
      tag_cpu = (v.req == 2'd1) ? "R7" : (v.req == 2'd2) ? "R9" :
                (v.req == 2'd3) ? "R10" : (v.x2 ? "R2" : "R1");
      tag_irq = (v.req == 2'd1) ? "R8" : (v.req == 2'd0) ? tag_cpu : "R9";
      @(negedge clk);
      idle_req = v.req[0];
      pd_req   = v.req[1];
      repeat (4) @(negedge clk);
      idle_req = 1'b0;
      pd_req   = 1'b0;
      repeat (2) @(negedge clk);
      count_en(24, a, b);
      chk({tag_cpu, " cpu enables"}, a, int'(v.cpu));
      chk({tag_cpu, " periph enables"}, b, int'(v.per));
      chk({"R11 flags ", tag_cpu}, int'(flags), int'(v.flg));
      irq = 1'b1;
      repeat (2) @(negedge clk);
      irq = 1'b0;
      repeat (2) @(negedge clk);
      count_en(24, a, b);
      chk({tag_irq, " cpu after irq"}, a, int'(v.cpu_irq));
    end

    // reset leaves power-down, R9 R11
    pin_reset(1'b0);
    chk("R9 R11 flags after reset exit", int'(flags), 0);
    count_en(24, a, b);
    chk("R9 enables after reset exit", a, 12);
    chk("R12 ram_clr at end", int'(ram_clr), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule